// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a received CAN identifier is kept. It holds eight acceptance code bytes and eight mask bytes, and groups them in one of four ways: as two 32-bit filters, as four 16-bit filters, as eight 8-bit filters, or as a closed filter that accepts nothing. A mask bit of 1 means the matching identifier bit is ignored. A frame is accepted when at least one filter matches. When several filters match, the lowest-numbered one is reported.

The receive path presents four identifier bytes together with a strobe. The block answers one cycle later with an accept pulse. The index of the winning filter goes into a small queue that runs in step with the receive FIFO. The index shown at the output always belongs to the message in the FIFO's foreground buffer. It changes only when a message enters that buffer: either a frame arrives while the queue is empty, or the FIFO shifts and another message is waiting.

A byte-wide register port gives access to a control register and to the code and mask bytes. Every write to the configuration is gated by the init-request and init-acknowledge pair. The control register can be read at any time.

Top module: `can_id_filter`

## Requirements
- R1: With mode 00, filter 0 compares code bytes 0..3 and filter 1 compares code bytes 4..7 against identifier bytes 0..3. Identifier byte 0 is `id_bytes[31:24]` and byte 3 is `id_bytes[7:0]`.
- R2: With mode 01, filter k (k = 0..3) compares code bytes 2k and 2k+1 against identifier bytes 0 and 1.
- R3: With mode 10, filter k (k = 0..7) compares code byte k against identifier byte 0.
- R4: With mode 11, no frame is accepted, no index is queued and `hit_idx` does not change.
- R5: A bit compares only where its mask bit is 0. `accept` pulses high in the cycle after `id_valid` if any filter matches, and is low otherwise.
- R6: The reported index is the binary number of the lowest-numbered matching filter, from 000 to 111.
- R7: `hit_idx` changes only when a message enters the foreground: an accepted frame arrives while no message is pending, or `fg_shift` occurs while a second message is pending. Otherwise it holds, including when a shift empties the queue.
- R8: If `fg_shift` and an accepted frame fall in the same cycle, the queue pops and pushes together. With one message pending, the new frame's index becomes `hit_idx`. With two or more pending, the second-oldest index becomes `hit_idx`.
- R9: The mode field, the code bytes and the mask bytes change only on writes made while both `init_req` and `init_ack` are 1. Writes at any other time leave them unchanged.
- R10: The hit field of the control register is read-only. Writes to it have no effect.
- R11: Reads work at any time. Address 0x00 returns the control register, with the mode in bits 5:4, the hit index in bits 2:0 and zeros elsewhere. Address 0x08+n returns code byte n and 0x10+n returns mask byte n.
- R12: After reset the mode is 00, `hit_idx` is 000, `accept` is 0, and all code and mask bytes are 0.
- R13: The queue holds `QUEUE_DEPTH` indices. An accepted frame that arrives while the queue is full (with no shift in that cycle) is still reported by `accept`, but its index is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| init_req | input | 1 | Initialisation request |
| init_ack | input | 1 | Initialisation acknowledge |
| id_valid | input | 1 | Received-identifier strobe |
| id_bytes | input | 32 | Four identifier bytes, byte 0 in bits 31:24 |
| fg_shift | input | 1 | Receive FIFO shifted a new message toward the foreground |
| accept | output | 1 | Frame accepted, one cycle after `id_valid` |
| hit_idx | output | 3 | Filter index of the foreground message |

## Verification
A foreground shift and the arrival of an accepted frame can fall in the same clock cycle. This is the case where the pop and the push of the index queue collide. The bench provokes it by raising `fg_shift` and `id_valid` on the same edge, once with one message pending and once with two. It then checks that `hit_idx` takes the new frame's index in the first case and the waiting older index in the second. Later shifts confirm that the queue order survived the collision.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int NUM_BYTES = 8;
    localparam int ID_BYTES  = 4;
    localparam int HIT_W     = 3;
    localparam int ADDR_W    = 5;

    typedef enum logic [1:0] {
        MODE_WIDE = 2'b00,
        MODE_HALF = 2'b01,
        MODE_BYTE = 2'b10,
        MODE_SHUT = 2'b11
    } filt_mode_e;

    typedef struct packed {
        logic             hit;
        logic [HIT_W-1:0] idx;
    } match_t;

    // register window select, taken from reg_addr[4:3]
    localparam logic [1:0] WIN_CTRL = 2'b00;
    localparam logic [1:0] WIN_CODE = 2'b01;
    localparam logic [1:0] WIN_MASK = 2'b10;

    function automatic logic byte_ok(input logic [7:0] id_b,
                                     input logic [7:0] code_b,
                                     input logic [7:0] mask_b);
        return ((id_b ^ code_b) & ~mask_b) == 8'h00;
    endfunction

    function automatic logic [7:0] id_byte(input logic [ID_BYTES*8-1:0] id,
                                           input int sel);
        return id[ID_BYTES*8-1-8*sel -: 8];
    endfunction

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
    import can_filt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [7:0]                    wdata,
    input  logic                          init_req,
    input  logic                          init_ack,
    input  logic [HIT_W-1:0]              hit_idx,
    output filt_mode_e                    mode,
    output logic [NUM_BYTES-1:0][7:0]     code,
    output logic [NUM_BYTES-1:0][7:0]     mask,
    output logic [7:0]                    rdata
);

    logic       cfg_open;
    logic [1:0] win;
    logic [2:0] slot;

    assign cfg_open = init_req & init_ack;
    assign win      = addr[4:3];
    assign slot     = addr[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_WIDE;
            code <= '0;
            mask <= '0;
        end else if (wr_en && cfg_open) begin
            unique case (win)
                WIN_CTRL: if (slot == 3'd0) mode <= filt_mode_e'(wdata[5:4]);
                WIN_CODE: code[slot] <= wdata;
                WIN_MASK: mask[slot] <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (win)
            WIN_CTRL: rdata = (slot == 3'd0) ? {2'b00, mode, 1'b0, hit_idx} : 8'h00;
            WIN_CODE: rdata = code[slot];
            WIN_MASK: rdata = mask[slot];
            default:  rdata = 8'h00;
        endcase
    end

    // R9: configuration frozen outside init
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        !(init_req && init_ack) |=> ($stable(mode) && $stable(code) && $stable(mask)));

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
    import can_filt_pkg::*;
(
    input  filt_mode_e                    mode,
    input  logic [NUM_BYTES-1:0][7:0]     code,
    input  logic [NUM_BYTES-1:0][7:0]     mask,
    input  logic [ID_BYTES*8-1:0]         id,
    output match_t                        result
);

    logic [NUM_BYTES-1:0]   eq_wide;
    logic [NUM_BYTES-1:0]   eq_half;
    logic [NUM_BYTES-1:0]   eq_byte;
    logic [NUM_BYTES/4-1:0] hit_wide;
    logic [NUM_BYTES/2-1:0] hit_half;
    logic [NUM_BYTES-1:0]   fvec;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_bytes
        assign eq_wide[b] = byte_ok(id_byte(id, b % 4), code[b], mask[b]);
        assign eq_half[b] = byte_ok(id_byte(id, b % 2), code[b], mask[b]);
        assign eq_byte[b] = byte_ok(id_byte(id, 0),     code[b], mask[b]);
    end

    for (genvar k = 0; k < NUM_BYTES/4; k++) begin : g_wide
        assign hit_wide[k] = &eq_wide[4*k +: 4];
    end

    for (genvar k = 0; k < NUM_BYTES/2; k++) begin : g_half
        assign hit_half[k] = &eq_half[2*k +: 2];
    end

    always_comb begin
        unique case (mode)
            MODE_WIDE: fvec = {{(NUM_BYTES-NUM_BYTES/4){1'b0}}, hit_wide};
            MODE_HALF: fvec = {{(NUM_BYTES-NUM_BYTES/2){1'b0}}, hit_half};
            MODE_BYTE: fvec = eq_byte;
            default:   fvec = '0;
        endcase
    end

    always_comb begin
        result.hit = |fvec;
        result.idx = '0;
        for (int k = NUM_BYTES-1; k >= 0; k--) begin
            if (fvec[k]) result.idx = HIT_W'(k);
        end
    end

endmodule

// File: rtl/can_filt_hitq.sv
module can_filt_hitq
    import can_filt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [HIT_W-1:0] push_idx,
    input  logic             pop,
    output logic [HIT_W-1:0] fg_idx
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [HIT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
    logic [CNT_W-1:0] count;
    logic             full, do_pop, do_push;

    assign rd_nxt  = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    assign wr_nxt  = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            fg_idx <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
            if (do_pop) begin
                if (count >= CNT_W'(2)) fg_idx <= slots[rd_nxt];
                else if (do_push)       fg_idx <= push_idx;
            end else if (do_push && count == '0) begin
                fg_idx <= push_idx;
            end
        end
    end

    // R7: foreground index holds unless a message enters the foreground
    p_fg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!pop && !(push && count == '0)) |=> $stable(fg_idx));

    // R13: occupancy never exceeds the depth
    p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R13: a full queue without a pop stays full and keeps its write pointer
    p_full_drop_r13: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> ($stable(wr_ptr) && full));

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [4:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        init_req,
    input  logic        init_ack,
    input  logic        id_valid,
    input  logic [31:0] id_bytes,
    input  logic        fg_shift,
    output logic        accept,
    output logic [2:0]  hit_idx
);

    filt_mode_e                mode;
    logic [NUM_BYTES-1:0][7:0] code;
    logic [NUM_BYTES-1:0][7:0] mask;
    match_t                    res;
    logic                      take;

    can_filt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .init_req (init_req),
        .init_ack (init_ack),
        .hit_idx  (hit_idx),
        .mode     (mode),
        .code     (code),
        .mask     (mask),
        .rdata    (reg_rdata)
    );

    can_filt_match u_match (
        .mode   (mode),
        .code   (code),
        .mask   (mask),
        .id     (id_bytes),
        .result (res)
    );

    assign take = id_valid & res.hit;

    can_filt_hitq #(.DEPTH(QUEUE_DEPTH)) u_hitq (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_idx (res.idx),
        .pop      (fg_shift),
        .fg_idx   (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) accept <= 1'b0;
        else     accept <= take;
    end

    // R4: closed mode never accepts
    p_closed_noacc_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHUT) |=> !accept);

    // R5: accept only follows a strobe
    p_accept_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !id_valid |=> !accept);

endmodule

// File: tb/can_id_filter_tb_top.sv
module can_id_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [4:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        init_req, init_ack;
    logic        id_valid;
    logic [31:0] id_bytes;
    logic        fg_shift;
    logic        accept;
    logic [2:0]  hit_idx;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    can_id_filter #(.QUEUE_DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_req(init_req),
        .init_ack(init_ack), .id_valid(id_valid), .id_bytes(id_bytes),
        .fg_shift(fg_shift), .accept(accept), .hit_idx(hit_idx)
    );

    // {mode[1:0], id[31:0], accept, idx[2:0]}
    localparam int NVEC = 12;
    localparam logic [37:0] VEC [NVEC] = '{
        {2'b00, 32'h10253040, 1'b1, 3'd0},
        {2'b00, 32'h50607080, 1'b1, 3'd1},
        {2'b00, 32'h10213041, 1'b0, 3'd0},
        {2'b01, 32'h102F0000, 1'b1, 3'd0},
        {2'b01, 32'h3040AAAA, 1'b1, 3'd1},
        {2'b01, 32'h70801234, 1'b1, 3'd3},
        {2'b01, 32'h11310000, 1'b0, 3'd0},
        {2'b01, 32'h50601111, 1'b1, 3'd2},
        {2'b10, 32'h10000000, 1'b1, 3'd0},
        {2'b10, 32'h2A000000, 1'b1, 3'd1},
        {2'b10, 32'h80FFFFFF, 1'b1, 3'd7},
        {2'b10, 32'h55000000, 1'b0, 3'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_init(input logic on);
        @(negedge clk);
        init_req = on; init_ack = on;
    endtask

    task automatic set_mode(input logic [1:0] m);
        set_init(1'b1);
        reg_write(5'h00, {2'b00, m, 4'b0000});
        set_init(1'b0);
    endtask

    // strobe one identifier, optionally with a foreground shift in the same cycle
    task automatic send(input logic [31:0] id, input logic shift, output logic acc);
        @(negedge clk);
        id_valid = 1'b1; id_bytes = id; fg_shift = shift;
        @(negedge clk);
        id_valid = 1'b0; fg_shift = 1'b0;
        acc = accept;
    endtask

    task automatic shift_fg();
        @(negedge clk);
        fg_shift = 1'b1;
        @(negedge clk);
        fg_shift = 1'b0;
    endtask

    function automatic string mode_req(input logic [1:0] m);
        return (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3";
    endfunction

    initial begin
        logic [7:0] rd;
        logic       acc;
        logic [2:0] held;
        logic [1:0] cur_mode;

        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        init_req = 1'b0; init_ack = 1'b0; id_valid = 1'b0; id_bytes = '0; fg_shift = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        check("R12 accept", accept, 0);
        check("R12 hit_idx", hit_idx, 0);
        reg_read(5'h00, rd); check("R12 ctrl", rd, 8'h00);
        reg_read(5'h0B, rd); check("R12 code3", rd, 8'h00);
        reg_read(5'h16, rd); check("R12 mask6", rd, 8'h00);

        // configure: codes 10..80, mask byte 1 ignores its low nibble
        set_init(1'b1);
        for (int i = 0; i < 8; i++) reg_write(5'(8 + i), 8'(16 * (i + 1)));
        reg_write(5'h11, 8'h0F);
        set_init(1'b0);
        reg_read(5'h0C, rd); check("R11 code4 read", rd, 8'h50);
        reg_read(5'h11, rd); check("R11 mask1 read", rd, 8'h0F);
        cur_mode = 2'b00;

        // table walk: R1 R2 R3 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] vm;
            vm = VEC[v][37:36];
            if (vm != cur_mode) begin
                set_mode(vm);
                cur_mode = vm;
            end
            send(VEC[v][35:4], 1'b0, acc);
            check({mode_req(vm), " R5 accept"}, acc, VEC[v][3]);
            if (VEC[v][3]) begin
                check({mode_req(vm), " R6 index"}, hit_idx, VEC[v][2:0]);
                shift_fg();
            end
        end

        // R6: duplicate code in filter 5, lowest index wins
        set_init(1'b1); reg_write(5'h0D, 8'h10); set_init(1'b0);
        send(32'h10000000, 1'b0, acc);
        check("R6 priority accept", acc, 1);
        check("R6 priority index", hit_idx, 0);
        shift_fg();
        // R5: fully masked filter 7 matches anything
        set_init(1'b1); reg_write(5'h17, 8'hFF); set_init(1'b0);
        send(32'h99000000, 1'b0, acc);
        check("R5 full mask accept", acc, 1);
        check("R6 index 111", hit_idx, 7);
        shift_fg();

        // R7: foreground tracking
        send(32'h20000000, 1'b0, acc); check("R7 arrive empty", hit_idx, 1);
        send(32'h30000000, 1'b0, acc); check("R7 hold on queue", hit_idx, 1);
        send(32'h40000000, 1'b0, acc); check("R7 hold on queue 2", hit_idx, 1);
        shift_fg(); check("R7 shift to 2", hit_idx, 2);
        shift_fg(); check("R7 shift to 3", hit_idx, 3);
        shift_fg(); check("R7 hold when emptied", hit_idx, 3);

        // R8: shift and accept in the same cycle
        send(32'h99000000, 1'b0, acc); check("R8 setup", hit_idx, 7);
        send(32'h20000000, 1'b1, acc);
        check("R8 one pending accept", acc, 1);
        check("R8 one pending index", hit_idx, 1);
        send(32'h30000000, 1'b0, acc); check("R8 hold", hit_idx, 1);
        send(32'h40000000, 1'b1, acc); check("R8 two pending index", hit_idx, 2);
        shift_fg(); check("R8 order kept", hit_idx, 3);
        shift_fg(); check("R8 drained hold", hit_idx, 3);

        // R13: full queue drops the extra index
        send(32'h10000000, 1'b0, acc);
        send(32'h20000000, 1'b0, acc);
        send(32'h30000000, 1'b0, acc);
        send(32'h40000000, 1'b0, acc);
        check("R13 fill index", hit_idx, 0);
        send(32'h99000000, 1'b0, acc);
        check("R13 overflow accept", acc, 1);
        check("R13 overflow hold", hit_idx, 0);
        shift_fg(); check("R13 pop 1", hit_idx, 1);
        shift_fg(); check("R13 pop 2", hit_idx, 2);
        shift_fg(); check("R13 pop 3", hit_idx, 3);
        shift_fg(); check("R13 dropped not stored", hit_idx, 3);

        // R10 / R11: hit field read-only, layout of control register
        held = hit_idx;
        set_init(1'b1); reg_write(5'h00, 8'hE4); set_init(1'b0);
        reg_read(5'h00, rd);
        check("R10 hit read-only", rd[2:0], 3'd3);
        check("R11 ctrl layout", rd, {2'b00, 2'b10, 1'b0, held});

        // R9: writes outside init ignored
        @(negedge clk); init_req = 1'b1; init_ack = 1'b0;
        reg_write(5'h00, 8'h30);
        reg_read(5'h00, rd); check("R9 mode locked (ack low)", rd[5:4], 2'b10);
        @(negedge clk); init_req = 1'b0; init_ack = 1'b1;
        reg_write(5'h08, 8'hEE);
        reg_read(5'h08, rd); check("R9 code locked (req low)", rd, 8'h10);
        set_init(1'b0);

        // R4: closed filter
        set_mode(2'b11);
        reg_read(5'h00, rd); check("R4 mode readback", rd[5:4], 2'b11);
        send(32'h10000000, 1'b0, acc);
        check("R4 closed accept", acc, 0);
        check("R4 closed hit", hit_idx, held);
        shift_fg();
        check("R4 nothing queued", hit_idx, held);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule